// File: doc/BRIEF.md
# Loop Trip-Count Exit Predictor

This block sits next to a main branch direction predictor and removes the exit misprediction of counted loops. It keeps a small, fully associative table of loop back-edge branches. For each one it stores the number of taken outcomes seen in the last complete pass of the loop, and the number seen so far in the current pass. Once two passes in a row end with the same count, the block trusts that count. It then predicts taken for every iteration except the one where the running count reaches the learned count, which it predicts not-taken.

The front end asks the lookup port with a branch address and a flag that marks a backward branch. In the same cycle it gets back a table hit, an override qualifier and a predicted direction. When the override qualifier is high, the block's direction replaces the main predictor's. The back end reports each resolved branch on the update port. That report drives the counters, the confidence, allocation and replacement. A flush input drops the running counts of every entry, together with any partially observed loop, when speculative updates have to be discarded.

A branch gets an entry only if it is a backward branch that has been taken at least a minimum number of times in a row (four by default) and is then seen not-taken. A single tracking register counts that run before the branch owns an entry. Replacement fills empty entries first and then evicts the entry that updates touched least recently. A parameter can select a round-robin pointer instead.

Top module: `loopx_pred`

## Requirements
- R1: After reset every entry is empty: a lookup of any address returns hit=0, override=0, taken=0.
- R2: A backward branch with no entry that is reported taken N times in a row, with N >= MIN_TRIP (default 4), and then not-taken gets an entry with learned count N and zero confidence. A later lookup returns hit=1, override=0, taken=1.
- R3: No entry is created for a backward run shorter than MIN_TRIP, nor for a branch whose updates carry backward=0. Lookups of such addresses return hit=0.
- R4: Each taken update of a held branch adds one to its running count. A lookup returns taken=1 while the running count is below the learned count, and taken=0 when it equals it.
- R5: A not-taken update whose running count equals the learned count raises the confidence, which saturates. The running count restarts at zero. With confidence of at least 1, override=1 for a lookup with backward=1 and override=0 for one with backward=0.
- R6: A not-taken update whose running count differs from the learned count clears the confidence, so override=0. The learned count becomes the new running count.
- R7: A cycle with flush=1 sets the running count of every entry to zero and discards any partially counted run of a branch without an entry. An update presented in the same cycle is ignored.
- R8: A new entry goes to an empty slot while one exists. When the table is full it replaces the entry least recently touched by an update. Lookups do not count as use.
- R9: Lookup results are combinational on the current table state. An update changes what lookups return from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | ADDR_W | Address of the branch being predicted |
| lk_backward | input | 1 | Lookup branch jumps to a lower address |
| lk_hit | output | 1 | Lookup address holds a table entry |
| lk_override | output | 1 | Prediction is trusted and replaces the main predictor |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_backward | input | 1 | Resolved branch jumps to a lower address |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| flush | input | 1 | Discard running counts and any partially counted run |

## Verification
The three lookup outputs are combinational, so each result is due in the cycle its lookup inputs are applied. The bench drives inputs shortly after a rising edge, and its monitor compares the queued expectation at the following falling edge. An update takes effect at the next rising edge. The bench therefore always follows an update with a lookup in a later cycle, except in one deliberate case. That case presents an update and a lookup of the same branch in one cycle and expects the pre-update answer, then expects the post-update answer one cycle later.

// File: rtl/loopx_pkg.sv
package loopx_pkg;

   // Action applied to the table on a given cycle
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_STEP  = 2'd1,   // taken outcome of a held branch
      ACT_CLOSE = 2'd2,   // not-taken outcome of a held branch
      ACT_ALLOC = 2'd3    // install a newly qualified loop
   } upd_act_e;

endpackage

// File: rtl/loopx_lru.sv
module loopx_lru #(
   parameter int N_ENTRIES = 16,
   parameter bit REPL_LRU  = 1'b1,
   localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_ENTRIES-1:0] vld,
   input  logic                 touch,
   input  logic [IW-1:0]        touch_idx,
   input  logic                 alloc,
   output logic [IW-1:0]        victim
);

   logic          free_found;
   logic [IW-1:0] free_idx;
   logic [IW-1:0] full_idx;

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (!vld[i] && !free_found) begin
            free_found = 1'b1;
            free_idx   = IW'(i);
         end
      end
   end

   generate
      if (REPL_LRU) begin : g_lru
         // ages form a permutation of 0..N-1; 0 is most recent
         logic [N_ENTRIES-1:0][IW-1:0] age_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N_ENTRIES; i++) age_q[i] <= IW'(i);
            end else if (touch) begin
               for (int i = 0; i < N_ENTRIES; i++) begin
                  if (IW'(i) == touch_idx)
                     age_q[i] <= '0;
                  else if (age_q[i] < age_q[touch_idx])
                     age_q[i] <= age_q[i] + 1'b1;
               end
            end
         end

         always_comb begin
            full_idx = '0;
            for (int i = 0; i < N_ENTRIES; i++) begin
               if (age_q[i] == IW'(N_ENTRIES - 1)) full_idx = IW'(i);
            end
         end
      end else begin : g_rr
         logic [IW-1:0] ptr_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               ptr_q <= '0;
            else if (alloc)
               ptr_q <= (ptr_q == IW'(N_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
         end

         assign full_idx = ptr_q;
      end
   endgenerate

   assign victim = free_found ? free_idx : full_idx;

endmodule

// File: rtl/loopx_cand.sv
module loopx_cand #(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 10,
   parameter int MIN_TRIP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              obs,     // backward branch without an entry resolved
   input  logic [ADDR_W-1:0] pc,
   input  logic              taken,
   output logic              ready,   // run of this pc has reached the minimum
   output logic [CNT_W-1:0]  run
);

   localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

   logic              vld_q;
   logic [ADDR_W-1:0] pc_q;
   logic [CNT_W-1:0]  run_q;
   logic              same_pc;

   assign same_pc = vld_q && (pc_q == pc);
   assign ready   = same_pc && (run_q >= CNT_W'(MIN_TRIP));
   assign run     = run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld_q <= 1'b0;
         pc_q  <= '0;
         run_q <= '0;
      end else if (obs) begin
         if (!taken) begin
            vld_q <= 1'b0;
            run_q <= '0;
         end else if (same_pc) begin
            if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
         end else begin
            vld_q <= 1'b1;
            pc_q  <= pc;
            run_q <= CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/loopx_pred.sv
module loopx_pred #(
   parameter int ADDR_W    = 32,
   parameter int N_ENTRIES = 16,
   parameter int CNT_W     = 10,
   parameter int CONF_W    = 2,
   parameter int MIN_TRIP  = 4,
   parameter bit REPL_LRU  = 1'b1,
   localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   input  logic              lk_backward,
   output logic              lk_hit,
   output logic              lk_override,
   output logic              lk_taken,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic              up_backward,
   input  logic              up_taken,
   input  logic              flush
);
   import loopx_pkg::*;

   localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

   generate
      if (N_ENTRIES < 2)                          $error("N_ENTRIES must be at least 2");
      if (CONF_W < 1)                             $error("CONF_W must be at least 1");
      if (MIN_TRIP < 1)                           $error("MIN_TRIP must be at least 1");
      if (CNT_W < 2 || MIN_TRIP > (2**CNT_W) - 1) $error("CNT_W too narrow for MIN_TRIP");
   endgenerate

   logic [N_ENTRIES-1:0]             vld_q;
   logic [N_ENTRIES-1:0][ADDR_W-1:0] tag_q;
   logic [N_ENTRIES-1:0][CNT_W-1:0]  trip_q;
   logic [N_ENTRIES-1:0][CNT_W-1:0]  iter_q;
   logic [N_ENTRIES-1:0][CONF_W-1:0] conf_q;

   logic [N_ENTRIES-1:0] lk_match;
   logic [N_ENTRIES-1:0] up_match;

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
      assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_pc);
      assign up_match[g] = vld_q[g] && (tag_q[g] == up_pc);
   end

   function automatic logic [IW-1:0] enc_idx(input logic [N_ENTRIES-1:0] m);
      logic [IW-1:0] r;
      r = '0;
      for (int i = 0; i < N_ENTRIES; i++) if (m[i]) r = IW'(i);
      return r;
   endfunction

   logic [IW-1:0] lk_idx, up_idx, victim;
   logic          up_hit;

   assign lk_idx = enc_idx(lk_match);
   assign up_idx = enc_idx(up_match);
   assign up_hit = |up_match;

   // ---------------- lookup path ----------------
   assign lk_hit      = |lk_match;
   assign lk_taken    = lk_hit && (iter_q[lk_idx] < trip_q[lk_idx]);
   assign lk_override = lk_hit && lk_backward && (conf_q[lk_idx] != '0);

   // ---------------- candidate run tracker ----------------
   logic             cand_obs, cand_ready;
   logic [CNT_W-1:0] cand_run;

   assign cand_obs = up_valid && !flush && !up_hit && up_backward;

   loopx_cand #(
      .ADDR_W  (ADDR_W),
      .CNT_W   (CNT_W),
      .MIN_TRIP(MIN_TRIP)
   ) u_cand (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(flush),
      .obs  (cand_obs),
      .pc   (up_pc),
      .taken(up_taken),
      .ready(cand_ready),
      .run  (cand_run)
   );

   // ---------------- action decode ----------------
   upd_act_e act;

   always_comb begin
      act = ACT_IDLE;
      if (up_valid && !flush) begin
         if (up_hit)
            act = up_taken ? ACT_STEP : ACT_CLOSE;
         else if (!up_taken && up_backward && cand_ready)
            act = ACT_ALLOC;
      end
   end

   // ---------------- replacement ----------------
   logic          rp_touch, rp_alloc;
   logic [IW-1:0] rp_idx;

   assign rp_alloc = (act == ACT_ALLOC);
   assign rp_touch = (act != ACT_IDLE);
   assign rp_idx   = rp_alloc ? victim : up_idx;

   loopx_lru #(
      .N_ENTRIES(N_ENTRIES),
      .REPL_LRU (REPL_LRU)
   ) u_repl (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (vld_q),
      .touch    (rp_touch),
      .touch_idx(rp_idx),
      .alloc    (rp_alloc),
      .victim   (victim)
   );

   // ---------------- entry state ----------------
   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      logic sel_up, sel_new;
      assign sel_up  = (up_idx == IW'(g));
      assign sel_new = (victim == IW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[g]  <= 1'b0;
            tag_q[g]  <= '0;
            trip_q[g] <= '0;
            iter_q[g] <= '0;
            conf_q[g] <= '0;
         end else if (flush) begin
            iter_q[g] <= '0;
         end else begin
            unique case (act)
               ACT_STEP: begin
                  if (sel_up && iter_q[g] != CNT_MAX) iter_q[g] <= iter_q[g] + 1'b1;
               end
               ACT_CLOSE: begin
                  if (sel_up) begin
                     trip_q[g] <= iter_q[g];
                     iter_q[g] <= '0;
                     if (iter_q[g] != trip_q[g])
                        conf_q[g] <= '0;
                     else if (conf_q[g] != CONF_MAX)
                        conf_q[g] <= conf_q[g] + 1'b1;
                  end
               end
               ACT_ALLOC: begin
                  if (sel_new) begin
                     vld_q[g]  <= 1'b1;
                     tag_q[g]  <= up_pc;
                     trip_q[g] <= cand_run;
                     iter_q[g] <= '0;
                     conf_q[g] <= '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/loopx_pred_chk.sv
module loopx_pred_chk #(
   parameter int ADDR_W    = 32,
   parameter int N_ENTRIES = 16,
   parameter int CNT_W     = 10,
   parameter int CONF_W    = 2,
   parameter int MIN_TRIP  = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            lk_backward,
   input logic                            lk_hit,
   input logic                            lk_override,
   input logic                            up_valid,
   input logic                            up_taken,
   input logic                            flush,
   input logic [N_ENTRIES-1:0]            vld_q,
   input logic [N_ENTRIES-1:0]            up_match,
   input logic [N_ENTRIES-1:0][CNT_W-1:0] trip_q,
   input logic [N_ENTRIES-1:0][CNT_W-1:0] iter_q,
   input logic [N_ENTRIES-1:0][CONF_W-1:0] conf_q
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   AST_OVR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      lk_override |-> (lk_hit && lk_backward));                                   // R5

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(up_match));                                                        // R2

   AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (iter_q == '0));                                                  // R7

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(vld_q[g]) |-> (conf_q[g] == '0 && trip_q[g] >= CNT_W'(MIN_TRIP)
                              && iter_q[g] == '0));                               // R2

      AST_ITER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (up_valid && !flush && up_match[g] && up_taken && iter_q[g] != CNT_MAX)
         |=> (iter_q[g] == $past(iter_q[g]) + 1'b1));                             // R4

      AST_CONF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         (up_valid && !flush && up_match[g] && !up_taken && iter_q[g] != trip_q[g])
         |=> (conf_q[g] == '0));                                                  // R6
   end

endmodule

bind loopx_pred loopx_pred_chk #(
   .ADDR_W   (ADDR_W),
   .N_ENTRIES(N_ENTRIES),
   .CNT_W    (CNT_W),
   .CONF_W   (CONF_W),
   .MIN_TRIP (MIN_TRIP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_backward(lk_backward),
   .lk_hit     (lk_hit),
   .lk_override(lk_override),
   .up_valid   (up_valid),
   .up_taken   (up_taken),
   .flush      (flush),
   .vld_q      (vld_q),
   .up_match   (up_match),
   .trip_q     (trip_q),
   .iter_q     (iter_q),
   .conf_q     (conf_q)
);

// File: tb/loopx_pred_tb.sv
`timescale 1ns/1ps
module loopx_pred_tb;

   localparam int AW = 32;
   localparam int WATCHDOG_CYC = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lk_pc = '0;
   logic          lk_backward = 1'b0;
   logic          lk_hit, lk_override, lk_taken;
   logic          up_valid = 1'b0;
   logic [AW-1:0] up_pc = '0;
   logic          up_backward = 1'b0;
   logic          up_taken = 1'b0;
   logic          flush = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   loopx_pred u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_pc      (lk_pc),
      .lk_backward(lk_backward),
      .lk_hit     (lk_hit),
      .lk_override(lk_override),
      .lk_taken   (lk_taken),
      .up_valid   (up_valid),
      .up_pc      (up_pc),
      .up_backward(up_backward),
      .up_taken   (up_taken),
      .flush      (flush)
   );

   typedef struct {
      logic  hit;
      logic  ovr;
      logic  tk;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;

   // monitor: compares queued expectations at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (lk_hit !== e.hit || lk_override !== e.ovr || lk_taken !== e.tk) begin
            n_errors++;
            $display("FAIL %s: got hit=%b ovr=%b tk=%b, expected hit=%b ovr=%b tk=%b",
                     e.req, lk_hit, lk_override, lk_taken, e.hit, e.ovr, e.tk);
         end
      end
   end

   task automatic step_begin();
      @(posedge clk);
      #2;
      up_valid = 1'b0;
      flush    = 1'b0;
   endtask

   task automatic upd(input logic [AW-1:0] pc, input logic bw, input logic tk);
      step_begin();
      up_valid    = 1'b1;
      up_pc       = pc;
      up_backward = bw;
      up_taken    = tk;
   endtask

   task automatic look(input logic [AW-1:0] pc, input logic bw,
                       input logic eh, input logic eo, input logic et, input string req);
      exp_t e;
      step_begin();
      lk_pc       = pc;
      lk_backward = bw;
      e.hit = eh; e.ovr = eo; e.tk = et; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic run_loop(input logic [AW-1:0] pc, input int n_taken, input logic bw);
      for (int i = 0; i < n_taken; i++) upd(pc, bw, 1'b1);
      upd(pc, bw, 1'b0);
   endtask

   localparam logic [AW-1:0] PC_A = 32'h0000_1000;
   localparam logic [AW-1:0] PC_B = 32'h0000_2000;
   localparam logic [AW-1:0] PC_C = 32'h0000_3000;
   localparam logic [AW-1:0] PC_E = 32'h0000_5000;

   function automatic logic [AW-1:0] pc_d(input int k);
      return 32'h0001_0000 + AW'(k * 16);
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: empty after reset
      look(PC_A, 1'b1, 0, 0, 0, "R1");

      // R2: run of 5 then exit allocates, no override yet
      run_loop(PC_A, 5, 1'b1);
      look(PC_A, 1'b1, 1, 0, 1, "R2");

      // R3: short run and forward branch are not allocated
      run_loop(PC_B, 3, 1'b1);
      look(PC_B, 1'b1, 0, 0, 0, "R3 short run");
      run_loop(PC_C, 6, 1'b0);
      look(PC_C, 1'b1, 0, 0, 0, "R3 forward");

      // R4: counting toward learned count 5
      for (int i = 0; i < 4; i++) upd(PC_A, 1'b1, 1'b1);
      look(PC_A, 1'b1, 1, 0, 1, "R4 below count");
      upd(PC_A, 1'b1, 1'b1);
      look(PC_A, 1'b1, 1, 0, 0, "R4 at count");

      // R5: matching exit raises confidence
      upd(PC_A, 1'b1, 1'b0);
      look(PC_A, 1'b1, 1, 1, 1, "R5 override");
      look(PC_A, 1'b0, 1, 0, 1, "R5 forward lookup");

      // R6: mismatching exit clears confidence and relearns 3
      run_loop(PC_A, 3, 1'b1);
      look(PC_A, 1'b1, 1, 0, 1, "R6 dropped");
      for (int i = 0; i < 3; i++) upd(PC_A, 1'b1, 1'b1);
      look(PC_A, 1'b1, 1, 0, 0, "R6 new count");
      upd(PC_A, 1'b1, 1'b0);
      look(PC_A, 1'b1, 1, 1, 1, "R6 retrusted");

      // R7: flush clears running count and wins over a same-cycle update
      upd(PC_A, 1'b1, 1'b1);
      upd(PC_A, 1'b1, 1'b1);
      look(PC_A, 1'b1, 1, 1, 1, "R7 before flush");
      upd(PC_A, 1'b1, 1'b1);
      flush = 1'b1;
      upd(PC_A, 1'b1, 1'b1);
      upd(PC_A, 1'b1, 1'b1);
      look(PC_A, 1'b1, 1, 1, 1, "R7 count restarted");
      upd(PC_A, 1'b1, 1'b1);
      look(PC_A, 1'b1, 1, 1, 0, "R7 exit iteration");
      upd(PC_A, 1'b1, 1'b0);
      // R7: flush discards a partial run of a branch without an entry
      for (int i = 0; i < 3; i++) upd(PC_B, 1'b1, 1'b1);
      step_begin();
      flush = 1'b1;
      run_loop(PC_B, 2, 1'b1);
      look(PC_B, 1'b1, 0, 0, 0, "R7 partial run dropped");

      // R8: fill remaining 15 slots, then evict least recently updated
      for (int k = 0; k < 15; k++) run_loop(pc_d(k), 4, 1'b1);
      look(PC_A, 1'b1, 1, 1, 1, "R8 kept after fill");
      look(pc_d(14), 1'b1, 1, 0, 1, "R8 last free slot");
      look(pc_d(0), 1'b1, 1, 0, 1, "R8 first filled");   // lookup does not touch
      run_loop(PC_A, 3, 1'b1);
      run_loop(PC_E, 4, 1'b1);
      look(PC_E, 1'b1, 1, 0, 1, "R8 new entry");
      look(pc_d(0), 1'b1, 0, 0, 0, "R8 oldest evicted");
      look(PC_A, 1'b1, 1, 1, 1, "R8 recent kept");
      look(pc_d(1), 1'b1, 1, 0, 1, "R8 next oldest kept");

      // R9: same-cycle lookup sees pre-update state
      for (int i = 0; i < 3; i++) upd(PC_E, 1'b1, 1'b1);
      upd(PC_E, 1'b1, 1'b1);
      begin
         exp_t e;
         lk_pc = PC_E; lk_backward = 1'b1;
         e.hit = 1; e.ovr = 0; e.tk = 1; e.req = "R9 same cycle";
         exp_q.push_back(e);
      end
      look(PC_E, 1'b1, 1, 0, 0, "R9 next cycle");

      step_begin();
      @(posedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < WATCHDOG_CYC) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got no completion, expected finish within %0d cycles",
                  WATCHDOG_CYC);
      end
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule